// File: doc/BRIEF.md
# Residue-Coded Reduced Lookup Cell

This block is a configurable combinational function cell. It can compute any boolean function of `N` inputs, but it selects among only 2^(N-1) slots instead of holding a 2^N-entry table. The upper `N-1` inputs address a slot. The lowest input is the residue variable. Each slot holds a 2-bit code, and that code makes the slot deliver constant 0, constant 1, the residue or the residue inverted. Every slot that needs the inverted residue takes it from one shared inverter.

Software-visible configuration is not modelled. The cell is loaded with a full truth-table output column of 2^N bits, and that column can arrive in two ways:
- in parallel, on a single write strobe;
- serially, one bit per cycle, with row 0 first, while a shift enable is high.

A compressor looks at each adjacent row pair (2k, 2k+1) of the column and turns it into the code for slot k. A small loader state machine controls when the slot-code register takes the new codes. It has three states:
- `LD_IDLE` waits. If the shift enable is high, it takes the first serial bit and moves to `LD_SHIFT`. Otherwise a parallel write captures the column and moves to `LD_COMMIT`.
- `LD_SHIFT` takes one bit in each cycle that the enable is high. After the last of the 2^N bits it moves to `LD_COMMIT`.
- `LD_COMMIT` raises the done pulse for one cycle. At the end of that cycle it writes the compressed codes into the slot register and returns to `LD_IDLE`. Load requests presented during this cycle are dropped.

Top module: `rescell_top`

## Requirements
- R1: Slot k drives the output when the value on `fn_in[N-1:1]` equals k. `fn_in[N-1]` is the most significant address bit.
- R2: The row pair (row 2k, row 2k+1) sets the code of slot k as follows:
  - (0,0) gives code 2'b00, constant 0.
  - (1,1) gives code 2'b01, constant 1.
  - (0,1) gives code 2'b10, which passes `fn_in[0]`.
  - (1,0) gives code 2'b11, which passes the inverse of `fn_in[0]`.
- R3: After any column has been committed, `fn_out` equals column bit number `fn_in`, where `fn_in` is read as an unsigned row index. This holds for every input value.
- R4: A parallel write taken in `LD_IDLE` behaves as follows:
  - `cfg_done` is high in the next cycle, for exactly one cycle.
  - During that cycle the previous function is still produced.
  - The new function appears after the clock edge that ends that cycle.
- R5: A serial load behaves as follows:
  - One bit is taken per cycle while `cfg_ser_en` is high, with row 0 first.
  - Cycles with the enable low take no bit.
  - `cfg_done` rises only after the 2^N-th bit, for one cycle.
  - Until then the previous function is kept.
- R6: A parallel write is ignored while a serial load is in progress. This covers the enable being high in `LD_IDLE` and any cycle in `LD_SHIFT`.
- R7: After reset all slot codes are zero. `fn_out` is 0 for every input and `cfg_done` is 0.
- R8: The column 8'h96 (odd parity of three inputs) loads the slots with residue, complement, complement, residue. The column 8'hE8 (majority of three) loads 0, residue, residue, 1. With N=3, each column produces its function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_par_we | input | 1 | Parallel column write strobe |
| cfg_par_col | input | 2^N | Full truth-table output column; bit i is row i |
| cfg_ser_en | input | 1 | Serial shift enable |
| cfg_ser_bit | input | 1 | Serial column bit, row 0 first |
| cfg_done | output | 1 | One-cycle pulse in the commit cycle |
| fn_in | input | N | Function inputs; bit 0 is the residue |
| fn_out | output | 1 | Combinational function output |

## Verification
The bench builds two instances: one with N=3 and one with N=6.

With N=3 every one of the 256 functions can be loaded and checked on all eight inputs. The same instance also covers the per-slot addressing and the four pair codes in isolation, and the two named examples.

The N=6 instance has a 32-slot selector and 64-bit serial loads. On it, random columns exercise the widest address decode. Its serial loads carry enable gaps and stray parallel writes, which shows that the counter and the ignore rule hold over a long shift.

// File: rtl/rescell_pkg.sv
package rescell_pkg;

    typedef enum logic [1:0] {
        SLOT_ZERO = 2'b00,
        SLOT_ONE  = 2'b01,
        SLOT_PASS = 2'b10,
        SLOT_INV  = 2'b11
    } slot_code_e;

    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_SHIFT  = 2'd1,
        LD_COMMIT = 2'd2
    } ld_state_e;

    // Row pair (even row, odd row) -> slot code
    function automatic slot_code_e pair_to_code(input logic row_even, input logic row_odd);
        slot_code_e code;
        unique case ({row_odd, row_even})
            2'b00:   code = SLOT_ZERO;
            2'b11:   code = SLOT_ONE;
            2'b10:   code = SLOT_PASS;
            default: code = SLOT_INV;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/rescell_compress.sv
module rescell_compress
    import rescell_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [(1<<N)-1:0]          col,
    output logic [(1<<(N-1))-1:0][1:0] codes
);
    localparam int SLOTS = 1 << (N - 1);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign codes[k] = pair_to_code(col[2*k], col[2*k+1]);
    end

endmodule

// File: rtl/rescell_select.sv
module rescell_select
    import rescell_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [(1<<(N-1))-1:0][1:0] codes,
    input  logic [N-1:0]               fn_in,
    output logic                       fn_out
);
    localparam int AW = N - 1;

    logic          residue;
    logic          residue_n;
    logic [AW-1:0] slot_addr;
    slot_code_e    slot_code;

    assign residue   = fn_in[0];
    assign residue_n = ~residue;          // the single shared inverter
    assign slot_addr = fn_in[N-1:1];
    assign slot_code = slot_code_e'(codes[slot_addr]);

    always_comb begin
        unique case (slot_code)
            SLOT_ZERO: fn_out = 1'b0;
            SLOT_ONE:  fn_out = 1'b1;
            SLOT_PASS: fn_out = residue;
            default:   fn_out = residue_n;
        endcase
    end

endmodule

// File: rtl/rescell_loader.sv
module rescell_loader
    import rescell_pkg::*;
#(
    parameter int ROWS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            par_we,
    input  logic [ROWS-1:0] par_col,
    input  logic            ser_en,
    input  logic            ser_bit,
    output logic [ROWS-1:0] col_q,
    output logic            commit
);
    localparam int CW = $clog2(ROWS);
    localparam logic [CW-1:0] LAST = CW'(ROWS - 1);

    ld_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          take_bit, take_par;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        take_bit = 1'b0;
        take_par = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                if (ser_en) begin
                    take_bit = 1'b1;
                    state_d  = LD_SHIFT;
                end else if (par_we) begin
                    take_par = 1'b1;
                    state_d  = LD_COMMIT;
                end
            end
            LD_SHIFT: begin
                if (ser_en) begin
                    take_bit = 1'b1;
                    if (cnt_q == LAST) state_d = LD_COMMIT;
                end
            end
            LD_COMMIT: state_d = LD_IDLE;
            default:   state_d = LD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        commit = (state_q == LD_COMMIT);
    end

    // Column shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            cnt_q <= '0;
        end else if (take_bit) begin
            col_q <= {ser_bit, col_q[ROWS-1:1]};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end else if (take_par) begin
            col_q <= par_col;
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/rescell_top.sv
module rescell_top
    import rescell_pkg::*;
#(
    parameter int N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_par_we,
    input  logic [(1<<N)-1:0]  cfg_par_col,
    input  logic               cfg_ser_en,
    input  logic               cfg_ser_bit,
    output logic               cfg_done,
    input  logic [N-1:0]       fn_in,
    output logic               fn_out
);
    localparam int ROWS  = 1 << N;
    localparam int SLOTS = 1 << (N - 1);

    logic [ROWS-1:0]       col_q;
    logic [SLOTS-1:0][1:0] next_codes;
    logic [SLOTS-1:0][1:0] slot_codes;

    rescell_loader #(.ROWS(ROWS)) loader_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .par_we  (cfg_par_we),
        .par_col (cfg_par_col),
        .ser_en  (cfg_ser_en),
        .ser_bit (cfg_ser_bit),
        .col_q   (col_q),
        .commit  (cfg_done)
    );

    rescell_compress #(.N(N)) compress_i (
        .col   (col_q),
        .codes (next_codes)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        slot_codes <= '0;
        else if (cfg_done) slot_codes <= next_codes;
    end

    rescell_select #(.N(N)) select_i (
        .codes  (slot_codes),
        .fn_in  (fn_in),
        .fn_out (fn_out)
    );

endmodule

// File: rtl/rescell_chk.sv
module rescell_chk #(
    parameter int N = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_par_we,
    input logic                       cfg_ser_en,
    input logic                       cfg_done,
    input logic [N-1:0]               fn_in,
    input logic                       fn_out,
    input logic [(1<<N)-1:0]          col,
    input logic [(1<<(N-1))-1:0][1:0] codes
);
    logic [(1<<N)-1:0] cap_q;
    logic              seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q  <= '0;
            seen_q <= 1'b0;
        end else if (cfg_done) begin
            cap_q  <= col;
            seen_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && seen_q) begin
            assert_table_match_R3: assert (fn_out == cap_q[fn_in])
                else $error("fn_out differs from committed column");
        end
        if (rst_n && !seen_q) begin
            assert_reset_zero_R7: assert (fn_out == 1'b0)
                else $error("fn_out nonzero before first load");
        end
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> !cfg_done);

    assert_codes_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> $stable(codes));

    assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> $past(cfg_par_we || cfg_ser_en));

endmodule

bind rescell_top rescell_chk #(.N(N)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_par_we (cfg_par_we),
    .cfg_ser_en (cfg_ser_en),
    .cfg_done   (cfg_done),
    .fn_in      (fn_in),
    .fn_out     (fn_out),
    .col        (col_q),
    .codes      (slot_codes)
);

// File: tb/rescell_top_tb_top.sv
`timescale 1ns/1ps
module rescell_top_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;
    logic rst_n;

    logic       a_pwe, a_sen, a_sbit, a_done, a_out;
    logic [7:0] a_col;
    logic [2:0] a_in;
    logic        b_pwe, b_sen, b_sbit, b_done, b_out;
    logic [63:0] b_col;
    logic [5:0]  b_in;

    rescell_top #(.N(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_par_we(a_pwe), .cfg_par_col(a_col),
        .cfg_ser_en(a_sen), .cfg_ser_bit(a_sbit), .cfg_done(a_done),
        .fn_in(a_in), .fn_out(a_out));

    rescell_top #(.N(6)) dut_wide_i (
        .clk(clk), .rst_n(rst_n), .cfg_par_we(b_pwe), .cfg_par_col(b_col),
        .cfg_ser_en(b_sen), .cfg_ser_bit(b_sbit), .cfg_done(b_done),
        .fn_in(b_in), .fn_out(b_out));

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [63:0] cur_tab [2];

    typedef struct {
        int    inst;
        int    row;
        logic  exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic logic out_of(int inst);
        return (inst == 0) ? a_out : b_out;
    endfunction

    function automatic logic done_of(int inst);
        return (inst == 0) ? a_done : b_done;
    endfunction

    function automatic int rows_of(int inst);
        return (inst == 0) ? 8 : 64;
    endfunction

    task automatic set_in(int inst, int row);
        if (inst == 0) a_in = 3'(row);
        else           b_in = 6'(row);
    endtask

    task automatic drive(int inst, logic pwe, logic [63:0] col, logic sen, logic sbit);
        if (inst == 0) begin
            a_pwe = pwe; a_col = col[7:0]; a_sen = sen; a_sbit = sbit;
        end else begin
            b_pwe = pwe; b_col = col; b_sen = sen; b_sbit = sbit;
        end
    endtask

    function automatic logic [63:0] mask(int inst, logic [63:0] t);
        return (inst == 0) ? {56'b0, t[7:0]} : t;
    endfunction

    // Driver: present one input, push the expected output
    task automatic eval(int inst, int row, string tag);
        item_t it;
        @(posedge clk); #1;
        set_in(inst, row);
        it.inst = inst; it.row = row; it.exp = cur_tab[inst][row]; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic sweep(int inst, string tag);
        for (int r = 0; r < rows_of(inst); r++) eval(inst, r, tag);
    endtask

    // Monitor: pop and compare
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                chk($sformatf("%s inst %0d row %0d", it.tag, it.inst, it.row),
                    out_of(it.inst), it.exp);
            end
        end
    end

    task automatic par_load(int inst, logic [63:0] t, string tag);
        int probe = 1;
        @(posedge clk); #1;
        drive(inst, 1'b1, t, 1'b0, 1'b0);
        @(posedge clk); #1;
        drive(inst, 1'b0, 64'b0, 1'b0, 1'b0);
        set_in(inst, probe);
        @(negedge clk);
        chk({tag, " R4 done in commit cycle"}, done_of(inst), 1'b1);
        chk({tag, " R4 old function held"}, out_of(inst), cur_tab[inst][probe]);
        cur_tab[inst] = mask(inst, t);
        @(posedge clk); #1;
        @(negedge clk);
        chk({tag, " R4 done one cycle"}, done_of(inst), 1'b0);
        chk({tag, " R4 new function"}, out_of(inst), cur_tab[inst][probe]);
    endtask

    task automatic ser_load(int inst, logic [63:0] t, bit gaps, string tag);
        int probe = 2;
        for (int i = 0; i < rows_of(inst); i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(posedge clk); #1;
                drive(inst, 1'b1, ~t, 1'b0, ~t[i]);
            end
            @(posedge clk); #1;
            drive(inst, gaps && (i % 5 == 2), ~t, 1'b1, t[i]);
        end
        set_in(inst, probe);
        @(negedge clk);
        chk({tag, " R5 no done before last bit"}, done_of(inst), 1'b0);
        chk({tag, " R5 old function before last bit"}, out_of(inst), cur_tab[inst][probe]);
        @(posedge clk); #1;
        drive(inst, 1'b0, 64'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk({tag, " R5 done after last bit"}, done_of(inst), 1'b1);
        chk({tag, " R5 old function in commit cycle"}, out_of(inst), cur_tab[inst][probe]);
        cur_tab[inst] = mask(inst, t);
        @(posedge clk); #1;
        @(negedge clk);
        chk({tag, " R5 done one cycle"}, done_of(inst), 1'b0);
        chk({tag, " R5 new function"}, out_of(inst), cur_tab[inst][probe]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] t;
        rst_n = 1'b0;
        drive(0, 1'b0, 64'b0, 1'b0, 1'b0);
        drive(1, 1'b0, 64'b0, 1'b0, 1'b0);
        a_in = '0; b_in = '0;
        cur_tab[0] = '0; cur_tab[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R7 done low after reset", a_done, 1'b0);
        chk("R7 wide done low after reset", b_done, 1'b0);
        sweep(0, "R7 reset output zero");
        sweep(1, "R7 reset output zero");

        par_load(0, 64'h96, "R8 parity");
        sweep(0, "R8 odd parity");
        par_load(0, 64'hE8, "R8 majority");
        sweep(0, "R8 majority");

        for (int k = 0; k < 4; k++) begin
            par_load(0, 64'h3 << (2 * k), "R1 slot select");
            sweep(0, $sformatf("R1 slot %0d only", k));
        end

        for (int p = 0; p < 4; p++) begin
            t = '0;
            for (int k = 0; k < 4; k++) begin
                t[2*k]   = p[0];
                t[2*k+1] = p[1];
            end
            par_load(0, t, "R2 pair code");
            sweep(0, $sformatf("R2 pair pattern %0d", p));
        end

        ser_load(0, 64'h5B, 1'b1, "R6 gaps");
        sweep(0, "R5 R6 serial with gaps and stray writes");
        ser_load(0, 64'hA3, 1'b0, "R5 plain");
        sweep(0, "R5 serial plain");

        for (int f = 0; f < 256; f++) begin
            par_load(0, 64'(f), "R3 exhaustive");
            sweep(0, "R3 exhaustive");
        end

        for (int j = 0; j < 4; j++) begin
            t = {$urandom(), $urandom()};
            par_load(1, t, "R3 wide parallel");
            sweep(1, "R3 wide random");
        end
        for (int j = 0; j < 3; j++) begin
            t = {$urandom(), $urandom()};
            ser_load(1, t, 1'b1, "R6 wide serial");
            sweep(1, "R5 R6 wide serial");
        end

        repeat (3) @(posedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule